// File: doc/BRIEF.md
# Floating-Point Operand Unpack and Classify

This block takes one operand of up to 128 bits and expands it into a single wide internal form for a floating-point datapath. The operand arrives as four 32-bit words packed into one bus. The first word sits in the top 32 bits and carries the sign and the exponent. A 3-bit type code says how to read the bits: as a 32-bit two's-complement integer, an IEEE single, an IEEE double or a 128-bit quad. The output is a sign, a class code, a signed unbiased exponent and a mantissa whose leading one sits at the MSB. A signalling NaN also raises an invalid-operation flag.

Integers and subnormals both go through one normalizer, which counts leading zeros and shifts left. Every format places its fraction directly below the mantissa MSB, so later stages see one layout. A NaN that arrives signalling is quieted, but its class still records that it was signalling. The unit accepts an operand with a valid/ready handshake and presents the result one cycle later from a single output register.

Top module: `fp_unpack`

## Requirements
- R1: `sign_o` equals bit 127 of the accepted operand (bit 31 of the first word) for every type code, the integer type and unsupported codes included.
- R2: A floating operand whose exponent field and fraction are both zero gives class ZERO (0), exponent 0 and mantissa 0.
- R3: A floating operand with a zero exponent field and a nonzero fraction gives class NUM (1). Its exponent is 1 - bias - lz, where lz is the left shift that brings the highest set fraction bit to mantissa bit 112, and no implicit one is added.
- R4: A normal floating operand gives class NUM with exponent = field - bias. The mantissa holds a one at bit 112 and the fraction at bits 111 downward. The fraction occupies bits 111:89 for a single (8/127/23), 111:60 for a double (11/1023/52) and 111:0 for a quad (15/16383/112). Bits of the operand below the format's width are ignored.
- R5: An all-ones exponent field with a zero fraction gives class INF (2), exponent 0 and mantissa 0.
- R6: An all-ones exponent field with the fraction's top bit set gives class QNAN (3). The aligned fraction passes through unchanged with exponent 0, and `invalid_o` stays 0.
- R7: An all-ones exponent field with a nonzero fraction and the fraction's top bit clear gives class SNAN (4). The mantissa is the aligned fraction with bit 111 set, the exponent is 0, and `invalid_o` is 1.
- R8: Type code 0 reads the top 32 bits as a two's-complement integer. Zero gives class ZERO. Any other value gives class NUM, with the magnitude normalized to bit 112 and exponent = index of the highest set bit of the magnitude; 0x80000000 gives magnitude 2^31 and exponent 31.
- R9: Every NUM result has mantissa bit 112 set, and `sticky_o` is 0 on every result.
- R10: Type codes 1, 2 and 3 select single, double and quad. Codes 4 to 7 raise `type_err_o` and give class ZERO, exponent 0, mantissa 0 and `invalid_o` 0. Supported codes leave `type_err_o` at 0.
- R11: `in_ready_o` is high when `out_valid_o` is low or `out_ready_i` is high. An operand accepted at a clock edge appears on the outputs with `out_valid_o` after that edge. The outputs stay stable while `out_valid_o` is high and `out_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Operand offered |
| in_ready_o | output | 1 | Operand can be accepted |
| type_i | input | 3 | 0 int, 1 single, 2 double, 3 quad, 4-7 unsupported |
| op_i | input | 128 | Operand, first word in bits 127:96 |
| out_valid_o | output | 1 | Result held on the outputs |
| out_ready_i | input | 1 | Consumer takes the result |
| sign_o | output | 1 | Sign bit |
| class_o | output | 3 | 0 ZERO, 1 NUM, 2 INF, 3 QNAN, 4 SNAN |
| exp_o | output | 18 | Signed unbiased exponent |
| mant_o | output | 113 | Mantissa, leading one at bit 112 |
| sticky_o | output | 1 | Sticky bit, cleared on unpack |
| invalid_o | output | 1 | Invalid-operation flag (signalling NaN) |
| type_err_o | output | 1 | Unsupported type code |

## Verification
The hardest cases to reach are where the normalizer shift is extreme: a subnormal with only its lowest fraction bit set, the most negative integer, and quad fractions that span all four words. These are the only cases where the count and the exponent adjustment reach their limits. The bench sweeps exponent fields at both boundaries (zero, one, bias, maximum minus one, all ones) against fraction patterns with single low bits, single high bits, all ones and the quiet bit alone. It also sweeps walking-one integers in both signs and fills the unused low words with a fixed pattern, so that any leakage from those bits shows up.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fp_class_e;

  localparam logic [2:0] TY_INT  = 3'd0;
  localparam logic [2:0] TY_SGL  = 3'd1;
  localparam logic [2:0] TY_DBL  = 3'd2;
  localparam logic [2:0] TY_QUAD = 3'd3;

  // index 1 single, 2 double, 3 quad
  function automatic int fmt_exp_bits(input int idx);
    return (idx == 1) ? 8 : (idx == 2) ? 11 : 15;
  endfunction

  function automatic int fmt_frac_bits(input int idx);
    return (idx == 1) ? 23 : (idx == 2) ? 52 : 112;
  endfunction
endpackage

// File: rtl/fp_fmt_decode.sv
module fp_fmt_decode #(
  parameter int OP_W      = 128,
  parameter int EXP_BITS  = 8,
  parameter int FRAC_BITS = 23,
  parameter int MANT_W    = 113
) (
  input  logic [OP_W-1:0]     op_i,
  output logic [EXP_BITS-1:0] exp_fld_o,
  output logic                exp_zero_o,
  output logic                exp_max_o,
  output logic                frac_nz_o,
  output logic [MANT_W-2:0]   frac_al_o
);
  localparam int PAD = MANT_W - 1 - FRAC_BITS;

  logic [FRAC_BITS-1:0] frac;

  assign exp_fld_o  = op_i[OP_W-2 -: EXP_BITS];
  assign frac       = op_i[OP_W-2-EXP_BITS -: FRAC_BITS];
  assign exp_zero_o = (exp_fld_o == '0);
  assign exp_max_o  = (exp_fld_o == '1);
  assign frac_nz_o  = |frac;
  assign frac_al_o  = (MANT_W-1)'(frac) << PAD;
endmodule

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W  = 113,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (d_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp_norm.sv
module fp_norm #(
  parameter int MANT_W = 113,
  parameter int EXP_W  = 18
) (
  input  logic [MANT_W-1:0]       mant_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic [MANT_W-1:0]       mant_o,
  output logic signed [EXP_W-1:0] exp_o
);
  localparam int CW = $clog2(MANT_W + 1);

  logic [CW-1:0] lz;

  fp_lzc #(.W(MANT_W)) u_lzc (.d_i(mant_i), .cnt_o(lz));

  assign mant_o = mant_i << lz;
  assign exp_o  = exp_i - $signed({{(EXP_W-CW){1'b0}}, lz});
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fpu_unpack_pkg::*;
#(
  parameter int MANT_W = 113,
  parameter int EXP_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [2:0]        type_i,
  input  logic [127:0]      op_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              sign_o,
  output logic [2:0]        class_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [MANT_W-1:0] mant_o,
  output logic              sticky_o,
  output logic              invalid_o,
  output logic              type_err_o
);
  localparam int OP_W   = 128;
  localparam int WORD_W = 32;
  localparam int NFMT   = 3;
  localparam int QBIT   = MANT_W - 2;

  logic [MANT_W-2:0]       frac_al  [NFMT+1];
  logic                    exp_zero [NFMT+1];
  logic                    exp_max  [NFMT+1];
  logic                    frac_nz  [NFMT+1];
  logic signed [EXP_W-1:0] nrm_exp  [NFMT+1];
  logic signed [EXP_W-1:0] sub_exp  [NFMT+1];

  assign frac_al[0]  = '0;
  assign exp_zero[0] = 1'b0;
  assign exp_max[0]  = 1'b0;
  assign frac_nz[0]  = 1'b0;
  assign nrm_exp[0]  = '0;
  assign sub_exp[0]  = '0;

  for (genvar g = 1; g <= NFMT; g++) begin : g_fmt
    localparam int EB   = fmt_exp_bits(g);
    localparam int FB   = fmt_frac_bits(g);
    localparam int BIAS = (1 << (EB - 1)) - 1;
    logic [EB-1:0] efld;

    fp_fmt_decode #(
      .OP_W(OP_W), .EXP_BITS(EB), .FRAC_BITS(FB), .MANT_W(MANT_W)
    ) u_dec (
      .op_i      (op_i),
      .exp_fld_o (efld),
      .exp_zero_o(exp_zero[g]),
      .exp_max_o (exp_max[g]),
      .frac_nz_o (frac_nz[g]),
      .frac_al_o (frac_al[g])
    );

    assign nrm_exp[g] = EXP_W'(efld) - EXP_W'(BIAS);
    assign sub_exp[g] = EXP_W'(1 - BIAS);
  end

  // integer path
  logic [WORD_W-1:0] int_w, int_mag;
  assign int_w   = op_i[OP_W-1 -: WORD_W];
  assign int_mag = int_w[WORD_W-1] ? (~int_w + 1'b1) : int_w;

  fp_class_e               cls;
  logic [MANT_W-1:0]       pre_mant, nrm_mant, res_mant;
  logic signed [EXP_W-1:0] pre_exp, nrm_e, res_exp;
  logic                    inv, err;
  logic [1:0]              fi;

  assign fi = type_i[1:0];

  always_comb begin
    cls      = CLS_ZERO;
    pre_mant = '0;
    pre_exp  = '0;
    inv      = 1'b0;
    err      = 1'b0;
    case (type_i)
      TY_INT: begin
        if (int_w != '0) begin
          cls      = CLS_NUM;
          pre_mant = {int_mag, {(MANT_W-WORD_W){1'b0}}};
          pre_exp  = EXP_W'(WORD_W - 1);
        end
      end
      TY_SGL, TY_DBL, TY_QUAD: begin
        if (exp_zero[fi]) begin
          if (frac_nz[fi]) begin
            cls      = CLS_NUM;
            pre_mant = {1'b0, frac_al[fi]};
            pre_exp  = sub_exp[fi];
          end
        end else if (exp_max[fi]) begin
          if (frac_nz[fi]) begin
            pre_mant = {1'b0, frac_al[fi]};
            if (!frac_al[fi][QBIT]) begin
              cls            = CLS_SNAN;
              inv            = 1'b1;
              pre_mant[QBIT] = 1'b1;
            end else begin
              cls = CLS_QNAN;
            end
          end else begin
            cls = CLS_INF;
          end
        end else begin
          cls      = CLS_NUM;
          pre_mant = {1'b1, frac_al[fi]};
          pre_exp  = nrm_exp[fi];
        end
      end
      default: err = 1'b1;
    endcase
  end

  fp_norm #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
    .mant_i(pre_mant), .exp_i(pre_exp), .mant_o(nrm_mant), .exp_o(nrm_e)
  );

  assign res_mant = (cls == CLS_NUM) ? nrm_mant : pre_mant;
  assign res_exp  = (cls == CLS_NUM) ? nrm_e : '0;

  // output stage
  logic accept;
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;
  assign sticky_o   = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sign_o      <= 1'b0;
      class_o     <= CLS_ZERO;
      exp_o       <= '0;
      mant_o      <= '0;
      invalid_o   <= 1'b0;
      type_err_o  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid_o <= 1'b1;
        sign_o      <= op_i[OP_W-1];
        class_o     <= cls;
        exp_o       <= res_exp;
        mant_o      <= res_mant;
        invalid_o   <= inv;
        type_err_o  <= err;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  a_r1_sign_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o && (sign_o == $past(op_i[OP_W-1])));

  a_r9_num_leading_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && class_o == CLS_NUM) |-> mant_o[MANT_W-1]);

  a_r7_snan_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && class_o == CLS_SNAN) |-> (invalid_o && mant_o[QBIT]));

  a_r6_qnan_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && class_o == CLS_QNAN) |-> (!invalid_o && mant_o[QBIT]));

  a_r10_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && type_err_o) |-> (class_o == CLS_ZERO && !invalid_o && mant_o == '0));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(class_o) && $stable(mant_o) && $stable(exp_o) && $stable(sign_o)));
endmodule

// File: tb/sim_fp_unpack.sv
module sim_fp_unpack;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [2:0]   ty = '0;
  logic [127:0] op = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         sign_o;
  logic [2:0]   cls_o;
  logic [17:0]  exp_o;
  logic [112:0] mant_o;
  logic         sticky_o, inv_o, err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [95:0] GARB = 96'hdead_beef_0123_4567_89ab_cdef;

  always #4 clk = ~clk;

  fp_unpack u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .type_i(ty), .op_i(op), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .sign_o(sign_o), .class_o(cls_o), .exp_o(exp_o), .mant_o(mant_o),
    .sticky_o(sticky_o), .invalid_o(inv_o), .type_err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  function automatic void model(input logic [2:0] t, input logic [127:0] o,
      output logic [2:0] c, output logic signed [17:0] ex, output logic [112:0] mt,
      output logic iv, output logic er, output string tag);
    int eb, fb, bias, p;
    int unsigned e;
    logic [127:0] fr;
    logic [31:0] v, mag;
    c = 3'd0; ex = '0; mt = '0; iv = 1'b0; er = 1'b0; tag = "R10";
    if (t == 3'd0) begin
      tag = "R8";
      v = o[127:96];
      if (v != 0) begin
        mag = v[31] ? -v : v;
        p = 0;
        for (int i = 0; i < 32; i++) if (mag[i]) p = i;
        c = 3'd1; ex = 18'(p); mt = 113'(mag) << (112 - p);
      end
    end else if (t <= 3'd3) begin
      eb = (t == 3'd1) ? 8 : (t == 3'd2) ? 11 : 15;
      fb = (t == 3'd1) ? 23 : (t == 3'd2) ? 52 : 112;
      bias = (1 << (eb - 1)) - 1;
      e = 32'((o << 1) >> (128 - eb));
      fr = (o << (1 + eb)) >> (128 - fb);
      if (e == 0) begin
        if (fr == 0) tag = "R2";
        else begin
          tag = "R3";
          p = 0;
          for (int i = 0; i < 112; i++) if (fr[i]) p = i;
          c = 3'd1; ex = 18'(1 - bias + p - fb); mt = 113'(fr) << (112 - p);
        end
      end else if (e == (1 << eb) - 1) begin
        if (fr == 0) begin tag = "R5"; c = 3'd2; end
        else begin
          mt = 113'(fr) << (112 - fb);
          if (!fr[fb-1]) begin tag = "R7"; c = 3'd4; iv = 1'b1; mt[111] = 1'b1; end
          else begin tag = "R6"; c = 3'd3; end
        end
      end else begin
        tag = "R4"; c = 3'd1; ex = 18'(int'(e) - bias);
        mt = (113'(1) << 112) | (113'(fr) << (112 - fb));
      end
    end else er = 1'b1;
  endfunction

  task automatic compare(input logic [2:0] t, input logic [127:0] o);
    logic [2:0] c; logic signed [17:0] ex; logic [112:0] mt; logic iv, er; string tag;
    model(t, o, c, ex, mt, iv, er, tag);
    chk(out_valid && cls_o == c && exp_o == ex && mant_o == mt && inv_o == iv && err_o == er,
        tag, $sformatf("ty=%0d op=%h cls %0d/%0d exp %0d/%0d mant %h/%h inv %0b/%0b err %0b/%0b",
        t, o, cls_o, c, $signed(exp_o), ex, mant_o, mt, inv_o, iv, err_o, er));
    chk(sign_o == o[127], "R1", $sformatf("sign %0b/%0b", sign_o, o[127]));
    chk(sticky_o == 1'b0, "R9", $sformatf("sticky %0b/0", sticky_o));
  endtask

  task automatic run_vec(input logic [2:0] t, input logic [127:0] o);
    @(negedge clk); ty = t; op = o; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    compare(t, o);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    automatic int se[7] = '{0, 1, 2, 127, 200, 254, 255};
    automatic logic [22:0] sf[8] = '{23'h0, 23'h1, 23'h2, 23'h400000, 23'h3fffff,
                                     23'h7fffff, 23'h200000, 23'h155555};
    automatic int de[5] = '{0, 1, 1023, 2046, 2047};
    automatic logic [51:0] df[7] = '{52'h0, 52'h1, 52'h8_0000_0000_0000, 52'h7_ffff_ffff_ffff,
                                     52'hf_ffff_ffff_ffff, 52'h0_0000_0010_0000, 52'h0_0100_0000_0000};
    automatic int qe[5] = '{0, 1, 16383, 32766, 32767};
    automatic logic [111:0] qf[7];
    logic [31:0] iv;

    qf[0] = '0; qf[1] = 112'(1); qf[2] = 112'(1) << 111; qf[3] = (112'(1) << 111) - 1;
    qf[4] = '1; qf[5] = 112'(1) << 64; qf[6] = 112'(1) << 31;

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1 && cls_o == 3'd0 && mant_o == '0,
        "R11", $sformatf("reset valid %0b/0 ready %0b/1", out_valid, in_ready));
    rst_n = 1'b1;
    @(negedge clk);

    // single precision sweep
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 8; b++)
          run_vec(3'd1, {1'(s), 8'(se[a]), sf[b], GARB});
    // double
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 7; b++)
          run_vec(3'd2, {1'(s), 11'(de[a]), df[b], GARB[63:0]});
    // quad
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 7; b++)
          run_vec(3'd3, {1'(s), 15'(qe[a]), qf[b]});
    // integers: walking ones both signs, extremes
    for (int i = 0; i < 32; i++) begin
      iv = 32'(1) << i;
      run_vec(3'd0, {iv, GARB});
      run_vec(3'd0, {-iv, GARB});
    end
    run_vec(3'd0, {32'h0, GARB});
    run_vec(3'd0, {32'h7fff_ffff, GARB});
    run_vec(3'd0, {32'hffff_ffff, GARB});
    run_vec(3'd0, {32'h1234_5678, GARB});
    // unsupported codes
    for (int t = 4; t < 8; t++) run_vec(3'(t), {32'hffc0_0001, GARB});

    // R11 back-pressure
    @(negedge clk); out_ready = 1'b0; ty = 3'd1; op = {32'h3f80_0000, GARB}; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && !in_ready, "R11", $sformatf("stall valid %0b/1 ready %0b/0", out_valid, in_ready));
    ty = 3'd0; op = {32'h8000_0000, GARB};
    repeat (3) @(negedge clk);
    compare(3'd1, {32'h3f80_0000, GARB});
    chk(!in_ready, "R11", $sformatf("ready during stall %0b/0", in_ready));
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    compare(3'd0, {32'h8000_0000, GARB});
    @(negedge clk);
    chk(!out_valid && in_ready, "R11", $sformatf("drain valid %0b/0 ready %0b/1", out_valid, in_ready));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule